// File: doc/BRIEF.md
# Mode-Banked Processor Register File

This block is the 32-bit integer register store of a load-store RISC core that runs in seven operating modes. The datapath always sees sixteen architectural registers, numbered 0 to 15. Which physical storage word sits behind an index depends on the mode the core is in. The current-status logic outside this block supplies that mode as a 5-bit code.

Indices 0 to 7 always map to one shared set of registers. The fast-interrupt mode has its own copies of indices 8 to 12. Every exception mode has its own stack pointer (index 13) and its own link register (index 14). Index 15 is the program counter. It is a single physical register, and it has a dedicated read port and a dedicated write port next to the general ones. Each exception mode also owns one saved-status word, which is reached through a separate port that follows the current mode. System mode works on exactly the user registers.

The block has two combinational read ports and one write port, and each of them can address any index. Writes take effect at the clock edge. A read in the same cycle returns the old contents.

Top module: `banked_regfile`

## Requirements
- R1: After an active-low asynchronous reset, every register and every saved-status word reads as zero.
- R2: Indices 0 to 7 map to one shared set. A value written there in any mode is read back in every other mode.
- R3: Indices 8 to 12 have a private set in fast-interrupt mode (code 10001). All other mode codes share a single set for these indices, and that set is separate from the fast-interrupt one.
- R4: Indices 13 and 14 are banked per mode. Fast-interrupt (10001), interrupt (10010), supervisor (10011), abort (10111) and undefined (11011) each have their own pair. User (10000), system (11111) and every unlisted code share the user pair.
- R5: In each of the five exception modes, the saved-status port reads and writes that mode's own word. A write appears on the following cycle.
- R6: In user or system mode, or under an unlisted code, the saved-status port reads zero and a write on it changes no saved word.
- R7: Both read ports are combinational and can address any index. A read of the register being written in the same cycle returns the old value, and the new value appears from the next cycle.
- R8: `pc_rdata` always shows index 15. `pc_we` loads `pc_wdata` into index 15 at the clock edge.
- R9: If the general write port targets index 15 in the same cycle as `pc_we`, the general write data is stored and the dedicated write is dropped.
- R10: A read of index 15 through a general read port returns the same value as `pc_rdata`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| mode | input | 5 | Current operating-mode code |
| ra_idx | input | 4 | Read port A index |
| ra_data | output | 32 | Read port A data |
| rb_idx | input | 4 | Read port B index |
| rb_data | output | 32 | Read port B data |
| wr_en | input | 1 | General write enable |
| wr_idx | input | 4 | General write index |
| wr_data | input | 32 | General write data |
| pc_rdata | output | 32 | Program counter value |
| pc_we | input | 1 | Dedicated program-counter write enable |
| pc_wdata | input | 32 | Dedicated program-counter write data |
| sav_we | input | 1 | Saved-status write enable |
| sav_wdata | input | 32 | Saved-status write data |
| sav_rdata | output | 32 | Saved-status word of the current mode |

## Verification
A wrong bank selection shows up at the read ports in the first cycle that reads the affected index under a different mode than the one that wrote it. Examples are a stack pointer leaking between interrupt and supervisor modes, or fast-interrupt writes showing up in user mode. A broken program-counter priority or a saved-status write taken in user mode appears on `pc_rdata` or `sav_rdata` one cycle after the write. The bench keeps a model of every physical word. It mixes random modes and indices, including unlisted codes, with directed aliasing sequences, so that a corrupted word is read back within a few cycles.

// File: rtl/banked_regfile.sv
module banked_regfile #(
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [4:0]    mode,
  input  logic [3:0]    ra_idx,
  output logic [DW-1:0] ra_data,
  input  logic [3:0]    rb_idx,
  output logic [DW-1:0] rb_data,
  input  logic          wr_en,
  input  logic [3:0]    wr_idx,
  input  logic [DW-1:0] wr_data,
  output logic [DW-1:0] pc_rdata,
  input  logic          pc_we,
  input  logic [DW-1:0] pc_wdata,
  input  logic          sav_we,
  input  logic [DW-1:0] sav_wdata,
  output logic [DW-1:0] sav_rdata
);
  localparam int NLO   = 8;
  localparam int NHI   = 5;
  localparam int NBANK = 6;
  localparam int NSAV  = NBANK - 1;
  localparam logic [4:0] M_USR = 5'b10000;
  localparam logic [4:0] M_FIQ = 5'b10001;
  localparam logic [4:0] M_IRQ = 5'b10010;
  localparam logic [4:0] M_SVC = 5'b10011;
  localparam logic [4:0] M_ABT = 5'b10111;
  localparam logic [4:0] M_UND = 5'b11011;
  localparam logic [4:0] M_SYS = 5'b11111;

  logic [DW-1:0] lo_q   [NLO];
  logic [DW-1:0] hi_usr [NHI];
  logic [DW-1:0] hi_fiq [NHI];
  logic [DW-1:0] sp_q   [NBANK];
  logic [DW-1:0] lr_q   [NBANK];
  logic [DW-1:0] sav_q  [NSAV];
  logic [DW-1:0] pc_q;

  logic [2:0] bank;
  logic [2:0] sav_sel;
  logic       is_fiq;
  logic       gp_pc_wr;

  always_comb begin
    case (mode)
      M_FIQ:   bank = 3'd1;
      M_IRQ:   bank = 3'd2;
      M_SVC:   bank = 3'd3;
      M_ABT:   bank = 3'd4;
      M_UND:   bank = 3'd5;
      default: bank = 3'd0;
    endcase
  end

  assign is_fiq   = (bank == 3'd1);
  assign sav_sel  = bank - 3'd1;
  assign gp_pc_wr = wr_en && (wr_idx == 4'd15);

  function automatic logic [DW-1:0] pick(input logic [3:0] i);
    if (i < 4'd8)        pick = lo_q[i[2:0]];
    else if (i < 4'd13)  pick = is_fiq ? hi_fiq[i[2:0]] : hi_usr[i[2:0]];
    else if (i == 4'd13) pick = sp_q[bank];
    else if (i == 4'd14) pick = lr_q[bank];
    else                 pick = pc_q;
  endfunction

  assign ra_data   = pick(ra_idx);
  assign rb_data   = pick(rb_idx);
  assign pc_rdata  = pc_q;
  assign sav_rdata = (bank == 3'd0) ? '0 : sav_q[sav_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < NLO; k++) lo_q[k] <= '0;
      for (int k = 0; k < NHI; k++) begin
        hi_usr[k] <= '0;
        hi_fiq[k] <= '0;
      end
      for (int k = 0; k < NBANK; k++) begin
        sp_q[k] <= '0;
        lr_q[k] <= '0;
      end
      for (int k = 0; k < NSAV; k++) sav_q[k] <= '0;
      pc_q <= '0;
    end else begin
      if (wr_en) begin
        if (wr_idx < 4'd8)                lo_q[wr_idx[2:0]] <= wr_data;
        else if (wr_idx < 4'd13 && is_fiq) hi_fiq[wr_idx[2:0]] <= wr_data;
        else if (wr_idx < 4'd13)           hi_usr[wr_idx[2:0]] <= wr_data;
        else if (wr_idx == 4'd13)          sp_q[bank] <= wr_data;
        else if (wr_idx == 4'd14)          lr_q[bank] <= wr_data;
      end
      if (gp_pc_wr)   pc_q <= wr_data;
      else if (pc_we) pc_q <= pc_wdata;
      if (sav_we && bank != 3'd0) sav_q[sav_sel] <= sav_wdata;
    end
  end

  a_r9_gp_pc_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_idx == 4'd15 && pc_we) |=> (pc_rdata == $past(wr_data)));

  a_r8_pc_port_load: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && !(wr_en && wr_idx == 4'd15)) |=> (pc_rdata == $past(pc_wdata)));

  a_r10_pc_alias: assert property (@(posedge clk) disable iff (!rst_n)
    (ra_idx == 4'd15) |-> (ra_data == pc_rdata));

  a_r6_user_sav_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == M_USR || mode == M_SYS) |-> (sav_rdata == '0));

  a_r7_write_visible: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(wr_en) && ra_idx == $past(wr_idx) && mode == $past(mode))
      |-> (ra_data == $past(wr_data)));

  a_r5_sav_update: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(sav_we) && mode == $past(mode) && mode != M_USR && mode != M_SYS
     && (mode == M_FIQ || mode == M_IRQ || mode == M_SVC || mode == M_ABT || mode == M_UND))
      |-> (sav_rdata == $past(sav_wdata)));
endmodule

// File: tb/banked_regfile_test.sv
`timescale 1ns/1ps
module banked_regfile_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [4:0]  mode = 5'b10000;
  logic [3:0]  ra_idx = '0, rb_idx = '0, wr_idx = '0;
  logic        wr_en = 1'b0, pc_we = 1'b0, sav_we = 1'b0;
  logic [31:0] wr_data = '0, pc_wdata = '0, sav_wdata = '0;
  logic [31:0] ra_data, rb_data, pc_rdata, sav_rdata;

  logic [31:0] m_gp [31];
  logic [31:0] m_sv [6];
  int checks = 0;
  int fails  = 0;
  logic [4:0] modes [8] = '{5'b10000, 5'b10001, 5'b10010, 5'b10011,
                            5'b10111, 5'b11011, 5'b11111, 5'b00101};

  banked_regfile uut (
    .clk(clk), .rst_n(rst_n), .mode(mode),
    .ra_idx(ra_idx), .ra_data(ra_data), .rb_idx(rb_idx), .rb_data(rb_data),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data),
    .pc_rdata(pc_rdata), .pc_we(pc_we), .pc_wdata(pc_wdata),
    .sav_we(sav_we), .sav_wdata(sav_wdata), .sav_rdata(sav_rdata));

  always #4 clk = ~clk;

  function automatic int bank_of(logic [4:0] m);
    case (m)
      5'b10001: return 1;
      5'b10010: return 2;
      5'b10011: return 3;
      5'b10111: return 4;
      5'b11011: return 5;
      default:  return 0;
    endcase
  endfunction

  function automatic int phys(int b, logic [3:0] i);
    if (i < 8)   return int'(i);
    if (i < 13)  return (b == 1) ? 13 + int'(i) - 8 : int'(i);
    if (i == 13) return 18 + b;
    if (i == 14) return 24 + b;
    return 30;
  endfunction

  function automatic string tag_of(logic [3:0] i);
    if (i < 8)  return "R2";
    if (i < 13) return "R3";
    if (i < 15) return "R4";
    return "R10";
  endfunction

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic step();
    int b;
    b = bank_of(mode);
    #1;
    chk((wr_en && wr_idx == ra_idx) ? "R7" : tag_of(ra_idx), ra_data, m_gp[phys(b, ra_idx)]);
    chk(tag_of(rb_idx), rb_data, m_gp[phys(b, rb_idx)]);
    chk("R8", pc_rdata, m_gp[30]);
    chk((b == 0) ? "R6" : "R5", sav_rdata, (b == 0) ? 32'h0 : m_sv[b]);
    @(posedge clk);
    if (wr_en) m_gp[phys(b, wr_idx)] = wr_data;
    if (pc_we && !(wr_en && wr_idx == 15)) m_gp[30] = pc_wdata;
    if (sav_we && b != 0) m_sv[b] = sav_wdata;
    @(negedge clk);
  endtask

  task automatic idle();
    wr_en = 0; pc_we = 0; sav_we = 0;
  endtask

  initial begin
    #(8 * 150000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    for (int i = 0; i < 31; i++) m_gp[i] = '0;
    for (int i = 0; i < 6; i++) m_sv[i] = '0;
    #3;
    for (int i = 0; i < 16; i++) begin
      ra_idx = 4'(i);
      #1 chk("R1", ra_data, 32'h0);
    end
    mode = 5'b10011;
    #1 chk("R1", sav_rdata, 32'h0);
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R4: supervisor and interrupt stack pointers separate; system equals user
    mode = 5'b10011; wr_en = 1; wr_idx = 13; wr_data = 32'h5500_0013; step();
    mode = 5'b11111; wr_idx = 13; wr_data = 32'h1111_0013; step();
    idle();
    mode = 5'b10010; ra_idx = 13; #1 chk("R4", ra_data, 32'h0);
    mode = 5'b10000; #1 chk("R4", ra_data, 32'h1111_0013);
    mode = 5'b10011; #1 chk("R4", ra_data, 32'h5500_0013);
    mode = 5'b01010; #1 chk("R4", ra_data, 32'h1111_0013);

    // R3: fast-interrupt private r8..r12
    mode = 5'b10001; wr_en = 1; wr_idx = 10; wr_data = 32'hF1F1_000A; step();
    idle(); mode = 5'b10010; ra_idx = 10; #1 chk("R3", ra_data, 32'h0);
    mode = 5'b10001; #1 chk("R3", ra_data, 32'hF1F1_000A);

    // R2: shared low registers
    mode = 5'b11011; wr_en = 1; wr_idx = 3; wr_data = 32'h0303_0303; step();
    idle(); mode = 5'b10001; ra_idx = 3; #1 chk("R2", ra_data, 32'h0303_0303);

    // R7: old value during write, new value next cycle
    mode = 5'b10000; wr_en = 1; wr_idx = 5; wr_data = 32'hAAAA_5555; ra_idx = 5;
    #1 chk("R7", ra_data, 32'h0);
    step(); idle(); #1 chk("R7", ra_data, 32'hAAAA_5555);

    // R9: general write to r15 beats dedicated write
    wr_en = 1; wr_idx = 15; wr_data = 32'h0000_1000; pc_we = 1; pc_wdata = 32'h0000_2000; step();
    idle(); #1 chk("R9", pc_rdata, 32'h0000_1000);
    pc_we = 1; pc_wdata = 32'h0000_3000; step(); idle();
    #1 chk("R8", pc_rdata, 32'h0000_3000);
    ra_idx = 15; #1 chk("R10", ra_data, 32'h0000_3000);

    // R5 / R6: saved status per exception mode, none in user/system
    mode = 5'b10111; sav_we = 1; sav_wdata = 32'h0000_00D7; step();
    mode = 5'b10000; sav_wdata = 32'hDEAD_0000; step();
    mode = 5'b11111; sav_wdata = 32'hDEAD_0001; step();
    idle();
    mode = 5'b10111; #1 chk("R5", sav_rdata, 32'h0000_00D7);
    mode = 5'b10011; #1 chk("R6", sav_rdata, 32'h0);
    mode = 5'b10000; #1 chk("R6", sav_rdata, 32'h0);

    for (int n = 0; n < 3000; n++) begin
      mode      = modes[$urandom_range(7)];
      ra_idx    = 4'($urandom);
      rb_idx    = 4'($urandom);
      wr_en     = ($urandom_range(3) != 0);
      wr_idx    = ($urandom_range(3) == 0) ? ra_idx : 4'($urandom);
      wr_data   = $urandom;
      pc_we     = ($urandom_range(3) == 0);
      pc_wdata  = $urandom;
      sav_we    = ($urandom_range(2) == 0);
      sav_wdata = $urandom;
      step();
    end
    idle();
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule